// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns the 16-bit offsets produced by a small processor core into 20-bit physical addresses. It keeps four 16-bit segment registers (code, stack, data, extra). For every access it selects one of them from the access type and an optional override request, multiplies that segment by sixteen and adds the offset. The sum wraps at 2^20.

Instruction fetches, stack pushes and pops, and string-destination writes are tied to their own segment, and an override request on them is dropped and flagged. General data accesses default to the data segment and accept an override to any of the four. The code segment changes only through a far transfer (jump, call or return). The other three change through an explicit load, for example a pop result or a load-pointer operation. Register writes land on the clock edge. The address path is purely combinational from the registered segments, so a request in the same cycle as a write sees the old segment value.

The request side is a valid-qualified stream with no back-pressure. The block has no storage on the address path, so a result is present in the same cycle as its request, and `addr_valid` simply mirrors `req_valid`. The core may issue a request every cycle.

Top module: `seg_addr_gen`

## Requirements
- R1: After reset the code segment holds FFFFh and the stack, data and extra segments hold 0000h.
- R2: `phys_addr` equals (selected segment × 16 + offset) modulo 2^20. With segment 1234h and offset 5678h the result is 179B8h. With FFFFh and FFFFh it is 0FFEFh.
- R3: An instruction fetch (`req_kind` = 0) always uses the code segment, whatever the override inputs are.
- R4: A stack access (`req_kind` = 1) always uses the stack segment, whatever the override inputs are.
- R5: A general data access (`req_kind` = 2) uses the data segment when `ovr_valid` is low. When `ovr_valid` is high it uses the segment coded in `ovr_seg`.
- R6: A string-destination access (`req_kind` = 3) always uses the extra segment, whatever the override inputs are.
- R7: `seg_used` reports the segment applied, coded 0 = code, 1 = stack, 2 = data, 3 = extra. `ovr_ignored` is high exactly when `req_valid` and `ovr_valid` are both high and `req_kind` is not 2.
- R8: When `far_xfer` is high at a clock edge, the code segment takes `far_seg`.
- R9: When `ld_valid` is high at a clock edge, the segment coded in `ld_target` (same coding as R7) takes `ld_value`. A load with `ld_target` = 0 leaves the code segment unchanged.
- R10: A request made in the same cycle as a segment write is formed from the segment value held before that write.
- R11: `addr_valid` equals `req_valid`. While `req_valid` is low, `phys_addr` and `seg_used` are 0 and `ovr_ignored` is low.
- R12: A far transfer and a load of another segment in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present this cycle |
| req_kind | input | 2 | 0 fetch, 1 stack, 2 data, 3 string destination |
| req_offset | input | 16 | Offset within the segment |
| ovr_valid | input | 1 | Segment override requested |
| ovr_seg | input | 2 | Requested segment (0 code, 1 stack, 2 data, 3 extra) |
| far_xfer | input | 1 | Far jump/call/return loads the code segment |
| far_seg | input | 16 | New code segment value |
| ld_valid | input | 1 | Explicit segment load |
| ld_target | input | 2 | Segment to load (code is refused) |
| ld_value | input | 16 | Value to load |
| addr_valid | output | 1 | Result valid, equal to req_valid |
| phys_addr | output | 20 | Physical address |
| seg_used | output | 2 | Segment applied to this request |
| ovr_ignored | output | 1 | Override requested but not allowed for this access type |

## Verification
On every cycle the assertions check the segment choice for each access type, the override-dropped flag, the address sum against the registered segment values, the idle outputs, and that the code segment moves only on a far transfer while loads land in their target. Some behaviour only the directed scenarios can show. These include the reset values, the worked example and wrap-around values, a refused load into the code segment as seen at the address output, the old-value result of a request made during a write, and a far transfer and a load landing together.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int NUM_SEG = 4;

  typedef enum logic [1:0] {
    SEG_CS = 2'd0,
    SEG_SS = 2'd1,
    SEG_DS = 2'd2,
    SEG_ES = 2'd3
  } seg_id_e;

  typedef enum logic [1:0] {
    ACC_FETCH  = 2'd0,
    ACC_STACK  = 2'd1,
    ACC_DATA   = 2'd2,
    ACC_STRDST = 2'd3
  } acc_kind_e;

  // Access types whose segment is fixed and refuses an override
  function automatic logic kind_is_pinned(acc_kind_e k);
    return k != ACC_DATA;
  endfunction
endpackage

// File: rtl/seg_regfile.sv
module seg_regfile
  import seg_pkg::*;
#(
  parameter int SEG_W = 16,
  parameter logic [SEG_W-1:0] RESET_CS = 16'hFFFF
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            far_xfer,
  input  logic [SEG_W-1:0]                far_seg,
  input  logic                            ld_valid,
  input  logic [1:0]                      ld_target,
  input  logic [SEG_W-1:0]                ld_value,
  output logic [NUM_SEG-1:0][SEG_W-1:0]   seg_q
);

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    localparam logic [SEG_W-1:0] RST_VAL = (g == int'(SEG_CS)) ? RESET_CS : '0;
    logic             wr_en;
    logic [SEG_W-1:0] wr_data;

    if (g == int'(SEG_CS)) begin : g_code
      // code segment: only far transfers, plain loads are refused
      assign wr_en   = far_xfer;
      assign wr_data = far_seg;
    end else begin : g_other
      assign wr_en   = ld_valid && (ld_target == 2'(g));
      assign wr_data = ld_value;
    end

    always_ff @(posedge clk) begin
      if (!rst_n)     seg_q[g] <= RST_VAL;
      else if (wr_en) seg_q[g] <= wr_data;
    end
  end

endmodule

// File: rtl/seg_select.sv
module seg_select
  import seg_pkg::*;
(
  input  logic [1:0] kind,
  input  logic       ovr_valid,
  input  logic [1:0] ovr_seg,
  output seg_id_e    sel,
  output logic       dropped
);

  acc_kind_e k;
  assign k = acc_kind_e'(kind);

  always_comb begin
    unique case (k)
      ACC_FETCH:  sel = SEG_CS;
      ACC_STACK:  sel = SEG_SS;
      ACC_STRDST: sel = SEG_ES;
      default:    sel = ovr_valid ? seg_id_e'(ovr_seg) : SEG_DS;
    endcase
    dropped = ovr_valid && kind_is_pinned(k);
  end

endmodule

// File: rtl/seg_adder.sv
module seg_adder #(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4,
  localparam int ADDR_W = SEG_W + SHIFT
) (
  input  logic [SEG_W-1:0]  seg,
  input  logic [OFF_W-1:0]  off,
  output logic [ADDR_W-1:0] addr
);

  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] off_ext;

  assign base    = {seg, {SHIFT{1'b0}}};
  assign off_ext = {{(ADDR_W-OFF_W){1'b0}}, off};
  // same-width sum: carry out of the top bit is dropped
  assign addr    = base + off_ext;

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_pkg::*;
#(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4,
  parameter logic [SEG_W-1:0] RESET_CS = 16'hFFFF,
  localparam int ADDR_W = SEG_W + SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [OFF_W-1:0]  req_offset,
  input  logic              ovr_valid,
  input  logic [1:0]        ovr_seg,
  input  logic              far_xfer,
  input  logic [SEG_W-1:0]  far_seg,
  input  logic              ld_valid,
  input  logic [1:0]        ld_target,
  input  logic [SEG_W-1:0]  ld_value,
  output logic              addr_valid,
  output logic [ADDR_W-1:0] phys_addr,
  output logic [1:0]        seg_used,
  output logic              ovr_ignored
);

  logic [NUM_SEG-1:0][SEG_W-1:0] seg_q;
  seg_id_e                       sel;
  logic                          dropped;
  logic [ADDR_W-1:0]             raw_addr;

  seg_regfile #(.SEG_W(SEG_W), .RESET_CS(RESET_CS)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .far_xfer  (far_xfer),
    .far_seg   (far_seg),
    .ld_valid  (ld_valid),
    .ld_target (ld_target),
    .ld_value  (ld_value),
    .seg_q     (seg_q)
  );

  seg_select u_sel (
    .kind      (req_kind),
    .ovr_valid (ovr_valid),
    .ovr_seg   (ovr_seg),
    .sel       (sel),
    .dropped   (dropped)
  );

  seg_adder #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT)) u_add (
    .seg  (seg_q[sel]),
    .off  (req_offset),
    .addr (raw_addr)
  );

  assign addr_valid  = req_valid;
  assign phys_addr   = req_valid ? raw_addr : '0;
  assign seg_used    = req_valid ? 2'(sel) : 2'd0;
  assign ovr_ignored = req_valid && dropped;

endmodule

// File: rtl/seg_addr_gen_chk.sv
module seg_addr_gen_chk #(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4,
  parameter int ADDR_W = SEG_W + SHIFT
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req_valid,
  input logic [1:0]             req_kind,
  input logic [OFF_W-1:0]       req_offset,
  input logic                   ovr_valid,
  input logic [1:0]             ovr_seg,
  input logic                   far_xfer,
  input logic [SEG_W-1:0]       far_seg,
  input logic                   ld_valid,
  input logic [1:0]             ld_target,
  input logic [SEG_W-1:0]       ld_value,
  input logic                   addr_valid,
  input logic [ADDR_W-1:0]      phys_addr,
  input logic [1:0]             seg_used,
  input logic                   ovr_ignored,
  input logic [3:0][SEG_W-1:0]  seg_q
);

  // independent formulation: segment times 2^SHIFT, truncated sum
  logic [ADDR_W-1:0] exp_addr;
  assign exp_addr = ADDR_W'(ADDR_W'(seg_q[seg_used]) * ADDR_W'(2 ** SHIFT))
                  + ADDR_W'(req_offset);

  p_addr_sum_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> phys_addr == exp_addr);

  p_fetch_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 2'd0) |-> seg_used == 2'd0);

  p_stack_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 2'd1) |-> seg_used == 2'd1);

  p_data_default_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 2'd2 && !ovr_valid) |-> seg_used == 2'd2);

  p_data_override_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 2'd2 && ovr_valid) |-> seg_used == ovr_seg);

  p_strdst_extra_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 2'd3) |-> seg_used == 2'd3);

  p_drop_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_ignored == (req_valid && ovr_valid && req_kind != 2'd2));

  p_far_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    far_xfer |=> seg_q[0] == $past(far_seg));

  p_code_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !far_xfer |=> $stable(seg_q[0]));

  p_load_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_target != 2'd0) |=> seg_q[$past(ld_target)] == $past(ld_value));

  p_valid_mirror_r11: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid == req_valid);

  p_idle_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (phys_addr == '0 && seg_used == 2'd0 && !ovr_ignored));

endmodule

bind seg_addr_gen seg_addr_gen_chk #(
  .SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT), .ADDR_W(ADDR_W)
) u_chk (.*);

// File: tb/test_seg_addr_gen.sv
module test_seg_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [1:0]  req_kind;
  logic [15:0] req_offset;
  logic        ovr_valid;
  logic [1:0]  ovr_seg;
  logic        far_xfer;
  logic [15:0] far_seg;
  logic        ld_valid;
  logic [1:0]  ld_target;
  logic [15:0] ld_value;
  logic        addr_valid;
  logic [19:0] phys_addr;
  logic [1:0]  seg_used;
  logic        ovr_ignored;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  seg_addr_gen i_seg_addr_gen (.*);

  function automatic logic [19:0] ea(logic [15:0] s, logic [15:0] o);
    logic [20:0] t;
    t = {5'b0, s} * 21'd16 + {5'b0, o};
    return t[19:0];
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic idle_inputs();
    req_valid = 0; req_kind = 0; req_offset = 0; ovr_valid = 0; ovr_seg = 0;
    far_xfer = 0; far_seg = 0; ld_valid = 0; ld_target = 0; ld_value = 0;
  endtask

  // drive a request at the falling edge and let the comb path settle
  task automatic req(logic [1:0] k, logic [15:0] off, logic ov, logic [1:0] os);
    @(negedge clk);
    req_valid = 1; req_kind = k; req_offset = off; ovr_valid = ov; ovr_seg = os;
    #2;
  endtask

  task automatic load(logic [1:0] tgt, logic [15:0] v);
    @(negedge clk);
    req_valid = 0; ld_valid = 1; ld_target = tgt; ld_value = v;
    @(negedge clk);
    ld_valid = 0;
  endtask

  task automatic far(logic [15:0] v);
    @(negedge clk);
    req_valid = 0; far_xfer = 1; far_seg = v;
    @(negedge clk);
    far_xfer = 0;
  endtask

  task automatic t_reset();
    idle_inputs();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #2;
    chk("R11 idle addr_valid", 32'(addr_valid), 0);
    chk("R11 idle phys_addr", 32'(phys_addr), 0);
    req(2'd0, 16'h0000, 0, 0);
    chk("R1 code seg reset", 32'(phys_addr), 32'h FFFF0);
    req(2'd1, 16'h0010, 0, 0);
    chk("R1 stack seg reset", 32'(phys_addr), 32'h00010);
    req(2'd2, 16'h0020, 0, 0);
    chk("R1 data seg reset", 32'(phys_addr), 32'h00020);
    req(2'd3, 16'h0030, 0, 0);
    chk("R1 extra seg reset", 32'(phys_addr), 32'h00030);
  endtask

  task automatic t_example();
    load(2'd2, 16'h1234);
    req(2'd2, 16'h5678, 0, 0);
    chk("R2 worked example", 32'(phys_addr), 32'h179B8);
    chk("R5 data default seg", 32'(seg_used), 2);
    chk("R11 addr_valid high", 32'(addr_valid), 1);
  endtask

  task automatic t_wrap();
    far(16'hFFFF);
    req(2'd0, 16'hFFFF, 0, 0);
    chk("R2 wrap", 32'(phys_addr), 32'h0FFEF);
    chk("R8 far wrote code seg", 32'(phys_addr), 32'(ea(16'hFFFF, 16'hFFFF)));
  endtask

  task automatic t_pinned();
    load(2'd1, 16'h4000);
    load(2'd3, 16'h6000);
    far(16'h2000);
    for (int s = 0; s < 4; s++) begin
      req(2'd0, 16'h0100, 1, 2'(s));
      chk("R3 fetch pinned", 32'(phys_addr), 32'(ea(16'h2000, 16'h0100)));
      chk("R7 fetch flag", 32'(ovr_ignored), 1);
      req(2'd1, 16'h0200, 1, 2'(s));
      chk("R4 stack pinned", 32'(phys_addr), 32'(ea(16'h4000, 16'h0200)));
      chk("R7 stack seg_used", 32'(seg_used), 1);
      req(2'd3, 16'h0300, 1, 2'(s));
      chk("R6 strdst pinned", 32'(phys_addr), 32'(ea(16'h6000, 16'h0300)));
      chk("R7 strdst seg_used", 32'(seg_used), 3);
    end
    req(2'd1, 16'h0200, 0, 0);
    chk("R7 no override no flag", 32'(ovr_ignored), 0);
  endtask

  task automatic t_override();
    logic [15:0] segs [4];
    segs[0] = 16'h2000; segs[1] = 16'h4000; segs[2] = 16'h1234; segs[3] = 16'h6000;
    for (int s = 0; s < 4; s++) begin
      req(2'd2, 16'h0042, 1, 2'(s));
      chk("R5 data override addr", 32'(phys_addr), 32'(ea(segs[s], 16'h0042)));
      chk("R5 data override seg", 32'(seg_used), 32'(s));
      chk("R7 data override flag", 32'(ovr_ignored), 0);
    end
  endtask

  task automatic t_load_cs_refused();
    load(2'd0, 16'h5555);
    req(2'd0, 16'h0000, 0, 0);
    chk("R9 code load refused", 32'(phys_addr), 32'h20000);
  endtask

  task automatic t_same_cycle_old();
    @(negedge clk);
    ld_valid = 1; ld_target = 2'd2; ld_value = 16'hAAAA;
    req_valid = 1; req_kind = 2'd2; req_offset = 16'h0001; ovr_valid = 0;
    #2;
    chk("R10 old value during write", 32'(phys_addr), 32'(ea(16'h1234, 16'h0001)));
    @(negedge clk);
    ld_valid = 0;
    #2;
    chk("R9 data load landed", 32'(phys_addr), 32'(ea(16'hAAAA, 16'h0001)));
  endtask

  task automatic t_both_writes();
    @(negedge clk);
    req_valid = 0;
    far_xfer = 1; far_seg = 16'h0ABC;
    ld_valid = 1; ld_target = 2'd3; ld_value = 16'h0DEF;
    @(negedge clk);
    far_xfer = 0; ld_valid = 0;
    req(2'd0, 16'h0004, 0, 0);
    chk("R12 code seg written", 32'(phys_addr), 32'(ea(16'h0ABC, 16'h0004)));
    req(2'd3, 16'h0004, 0, 0);
    chk("R12 extra seg written", 32'(phys_addr), 32'(ea(16'h0DEF, 16'h0004)));
  endtask

  task automatic t_idle();
    @(negedge clk);
    req_valid = 0; req_kind = 2'd0; ovr_valid = 1; req_offset = 16'h1111;
    #2;
    chk("R11 idle phys_addr zero", 32'(phys_addr), 0);
    chk("R11 idle flag low", 32'(ovr_ignored), 0);
    chk("R11 idle seg_used zero", 32'(seg_used), 0);
  endtask

  initial begin
    t_reset();
    t_example();
    t_wrap();
    t_pinned();
    t_override();
    t_load_cs_refused();
    t_same_cycle_old();
    t_both_writes();
    t_idle();
    repeat (2) @(negedge clk);
    report();
  end

  initial begin
    #(8 * 20000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    report();
  end

endmodule